// File: doc/BRIEF.md
# Watermark-Driven Receive Flow Controller

This block watches how full a receive data FIFO is and decides when the far-end sender must be slowed down. In full duplex it raises a request for a pause frame when occupancy climbs to a high mark. Later, once occupancy has dropped under a low mark, it asks for a pause frame with a zero pause time so the partner resumes at once. The gap between the two marks keeps the pair of requests apart, and the zero-time request is only ever made after a high-mark pause has been acknowledged by the transmit side.

In half duplex no pause frames are requested. Instead, each qualifying incoming frame that arrives while the FIFO is at or above the high mark is jammed for a programmed number of cycles. A small register holds the two marks, the jam duration code and four mode bits. The pause time for the high-mark request comes from an input. Nothing is requested and nothing is jammed while the transmitter is disabled.

Top module: `rxfc_top`

## Requirements
- R1: After reset the register reads zero, `pause_req` is 0 and `jam` is 0.
- R2: The register layout is high mark in bits 23:16, low mark in bits 15:8, jam duration code in bits 7:4 and mode in bits 3:0. Mode bit 0 enables full-duplex pause, bit 1 enables half-duplex jamming, bit 2 makes jamming need `frm_match`, and bit 3 forces jam in half duplex. Bits 31:24 read as zero.
- R3: In full duplex with mode bit 0 set, an occupancy of at least high mark × 64 bytes raises exactly one request carrying `pause_time_cfg`. No further request follows while occupancy stays at or above that level.
- R4: After that request is acknowledged, occupancy below low mark × 64 bytes raises exactly one request with pause time 0. Occupancy equal to low mark × 64 raises none.
- R5: With no acknowledged high-mark request pending, occupancy below the low mark raises no request.
- R6: A request stays asserted, with a stable pause time, until `pause_ack` is seen.
- R7: In half duplex with mode bit 1 set, a frame strobe seen while occupancy is at or above the high mark raises `jam` for exactly (code+1) × `JAM_STEP` cycles. A strobe seen below the high mark raises no jam.
- R8: With mode bit 2 set, a strobe whose `frm_match` is 0 raises no jam.
- R9: A qualifying strobe during an active jam restarts the full duration.
- R10: In full duplex `jam` stays 0 and the duration code has no effect.
- R11: While `tx_en` is 0, `pause_req` and `jam` stay 0.
- R12: If the low mark is at or above the high mark, each excursion gives one high-mark and one zero-time request, then nothing more until occupancy falls below the high mark.
- R13: Clearing mode bit 0 drops a pending resume, so no zero-time request follows after it is set again.
- R14: With mode bit 3 set in half duplex with `tx_en` high, `jam` is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 24 | Register write data, bits 23:0 |
| cfg_rdata | output | 32 | Register read data |
| pause_time_cfg | input | TIME_W | Pause time used for high-mark requests |
| fill_bytes | input | LEVEL_W | FIFO occupancy in bytes |
| fdx | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_en | input | 1 | Transmitter enabled |
| frm_start | input | 1 | One-cycle strobe at start of an incoming frame |
| frm_match | input | 1 | Frame meets the match criterion |
| pause_ack | input | 1 | Transmit side accepts the current pause request |
| pause_req | output | 1 | Pause frame request, held until acknowledged |
| pause_time | output | TIME_W | Pause time of the current request |
| jam | output | 1 | Backpressure (jam) active |

## Verification
The assertions assume that `pause_ack` is raised only while `pause_req` is high. They also assume that `fill_bytes` and the register settle before a frame strobe is judged against the marks, since the mark comparison is registered. The stimulus raises the acknowledge at a falling edge only when a request is visible, and drops it on the next falling edge. It changes occupancy and configuration and then waits several cycles before strobing a frame or counting requests. Mode changes are made while no handshake is in flight, except in the test that withdraws flow control on purpose.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

  typedef enum logic [2:0] {
    FC_IDLE    = 3'd0,
    FC_REQ_HI  = 3'd1,
    FC_HELD    = 3'd2,
    FC_REQ_RES = 3'd3,
    FC_WAIT    = 3'd4
  } fc_state_e;

  typedef struct packed {
    logic [7:0] hi_mark;
    logic [7:0] lo_mark;
    logic [3:0] jam_code;
    logic [3:0] mode;
  } rxfc_cfg_t;

  localparam int unsigned MODE_FD_PAUSE = 0;
  localparam int unsigned MODE_HD_JAM   = 1;
  localparam int unsigned MODE_QUALIFY  = 2;
  localparam int unsigned MODE_FORCE    = 3;

  function automatic int unsigned jam_cycles(input logic [3:0] code, input int unsigned step);
    return (int'(code) + 1) * step;
  endfunction

endpackage

// File: rtl/rxfc_cfg_regs.sv
module rxfc_cfg_regs
  import rxfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [23:0] wdata,
  output rxfc_cfg_t   cfg_o,
  output logic [31:0] rdata
);

  rxfc_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = rxfc_cfg_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
  assign rdata = {8'h00, cfg_q};

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cfg_q == rxfc_cfg_t'($past(wdata)));

endmodule

// File: rtl/rxfc_level_cmp.sv
module rxfc_level_cmp #(
  parameter int unsigned LEVEL_W    = 16,
  parameter int unsigned UNIT_SHIFT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEVEL_W-1:0] fill,
  input  logic [7:0]         hi_mark,
  input  logic [7:0]         lo_mark,
  output logic               above_hi,
  output logic               below_lo
);

  localparam int unsigned TH_W  = 8 + UNIT_SHIFT;
  localparam int unsigned CMP_W = (LEVEL_W > TH_W) ? LEVEL_W : TH_W;

  logic [CMP_W-1:0] lvl_w, th_hi_w, th_lo_w;
  logic             above_d, below_d, above_q, below_q;

  always_comb begin
    lvl_w   = CMP_W'(fill);
    th_hi_w = CMP_W'({hi_mark, {UNIT_SHIFT{1'b0}}});
    th_lo_w = CMP_W'({lo_mark, {UNIT_SHIFT{1'b0}}});
    above_d = (lvl_w >= th_hi_w);
    below_d = (lvl_w <  th_lo_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      above_q <= 1'b0;
      below_q <= 1'b0;
    end else begin
      above_q <= above_d;
      below_q <= below_d;
    end
  end

  assign above_hi = above_q;
  assign below_lo = below_q;

  assert_marks_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (above_q && below_q) |-> $past(th_lo_w > th_hi_w));

endmodule

// File: rtl/rxfc_pause_fsm.sv
module rxfc_pause_fsm
  import rxfc_pkg::*;
#(
  parameter int unsigned TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fc_on,
  input  logic              tx_en,
  input  logic              above_hi,
  input  logic              below_lo,
  input  logic              ack,
  input  logic [TIME_W-1:0] time_cfg,
  output logic              req_o,
  output logic [TIME_W-1:0] time_o
);

  fc_state_e st_q, st_d;
  logic      hs_done;

  assign req_o   = tx_en && ((st_q == FC_REQ_HI) || (st_q == FC_REQ_RES));
  assign time_o  = (st_q == FC_REQ_HI) ? time_cfg : '0;
  assign hs_done = req_o && ack;

  always_comb begin
    st_d = st_q;
    case (st_q)
      FC_IDLE:    if (fc_on && tx_en && above_hi) st_d = FC_REQ_HI;
      FC_REQ_HI:  if (!fc_on) st_d = FC_IDLE;
                  else if (hs_done) st_d = FC_HELD;
      FC_HELD:    if (!fc_on) st_d = FC_IDLE;
                  else if (below_lo) st_d = FC_REQ_RES;
      FC_REQ_RES: if (!fc_on) st_d = FC_IDLE;
                  else if (hs_done) st_d = FC_WAIT;
      FC_WAIT:    if (!fc_on || !above_hi) st_d = FC_IDLE;
      default:    st_d = FC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FC_IDLE;
    else        st_q <= st_d;
  end

  assert_resume_after_pause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == FC_REQ_RES && $past(st_q) != FC_REQ_RES) |-> $past(st_q) == FC_HELD);

  assert_req_time_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack && fc_on) |=> ($stable(time_o) || !req_o || !fc_on));

endmodule

// File: rtl/rxfc_jam_timer.sv
module rxfc_jam_timer
  import rxfc_pkg::*;
#(
  parameter int unsigned JAM_STEP = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hd_on,
  input  logic       tx_en,
  input  logic       fdx,
  input  logic       force_jam,
  input  logic       qualify,
  input  logic       above_hi,
  input  logic       frm_start,
  input  logic       frm_match,
  input  logic [3:0] code,
  output logic       jam_o
);

  localparam int unsigned MAX_LEN = 16 * JAM_STEP;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit, cnt_en;

  assign hit    = hd_on && above_hi && frm_start && (!qualify || frm_match);
  assign cnt_en = !hd_on || hit || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!hd_on)            cnt_d = '0;
    else if (hit)          cnt_d = CNT_W'(jam_cycles(code, JAM_STEP));
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign jam_o = tx_en && !fdx && ((cnt_q != '0) || force_jam);

  assert_hit_jams_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (jam_o || !tx_en || fdx));

  assert_idle_no_jam_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hd_on && !force_jam) |=> (!jam_o || hd_on || force_jam));

endmodule

// File: rtl/rxfc_top.sv
module rxfc_top
  import rxfc_pkg::*;
#(
  parameter int unsigned LEVEL_W    = 16,
  parameter int unsigned UNIT_SHIFT = 6,
  parameter int unsigned TIME_W     = 16,
  parameter int unsigned JAM_STEP   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [23:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [TIME_W-1:0] pause_time_cfg,
  input  logic [LEVEL_W-1:0] fill_bytes,
  input  logic              fdx,
  input  logic              tx_en,
  input  logic              frm_start,
  input  logic              frm_match,
  input  logic              pause_ack,
  output logic              pause_req,
  output logic [TIME_W-1:0] pause_time,
  output logic              jam
);

  logic      rst_meta_q, rst_sync_q;
  rxfc_cfg_t cfg;
  logic      above_hi, below_lo, fc_on, hd_on, force_jam;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  rxfc_cfg_regs u_regs (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .wr_en (cfg_we),
    .wdata (cfg_wdata),
    .cfg_o (cfg),
    .rdata (cfg_rdata)
  );

  rxfc_level_cmp #(.LEVEL_W(LEVEL_W), .UNIT_SHIFT(UNIT_SHIFT)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .fill     (fill_bytes),
    .hi_mark  (cfg.hi_mark),
    .lo_mark  (cfg.lo_mark),
    .above_hi (above_hi),
    .below_lo (below_lo)
  );

  assign fc_on     = cfg.mode[MODE_FD_PAUSE] && fdx;
  assign hd_on     = cfg.mode[MODE_HD_JAM] && !fdx && tx_en;
  assign force_jam = cfg.mode[MODE_FORCE];

  rxfc_pause_fsm #(.TIME_W(TIME_W)) u_pause (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .fc_on    (fc_on),
    .tx_en    (tx_en),
    .above_hi (above_hi),
    .below_lo (below_lo),
    .ack      (pause_ack),
    .time_cfg (pause_time_cfg),
    .req_o    (pause_req),
    .time_o   (pause_time)
  );

  rxfc_jam_timer #(.JAM_STEP(JAM_STEP)) u_jam (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .hd_on     (hd_on),
    .tx_en     (tx_en),
    .fdx       (fdx),
    .force_jam (force_jam),
    .qualify   (cfg.mode[MODE_QUALIFY]),
    .above_hi  (above_hi),
    .frm_start (frm_start),
    .frm_match (frm_match),
    .code      (cfg.jam_code),
    .jam_o     (jam)
  );

  assert_tx_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !tx_en |-> (!pause_req && !jam));

  assert_single_hi_pause_R3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (pause_req && pause_ack && pause_time != '0) |=> (!pause_req || pause_time == '0));

endmodule

// File: tb/rxfc_top_tb_top.sv
`timescale 1ns/1ps
module rxfc_top_tb_top;

  localparam int unsigned LW   = 12;
  localparam int unsigned TW   = 16;
  localparam int unsigned STEP = 2;
  localparam logic [TW-1:0] PT = 16'h1234;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [23:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic [LW-1:0] fill_bytes = '0;
  logic          fdx = 1'b1, tx_en = 1'b1, frm_start = 1'b0, frm_match = 1'b0;
  logic          pause_ack = 1'b0;
  logic          pause_req;
  logic [TW-1:0] pause_time;
  logic          jam;

  int n_checks = 0, n_errors = 0, n_hi = 0, n_zero = 0;
  logic [TW-1:0] last_hi_time = '0;
  logic hold_ack = 1'b0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  rxfc_top #(.LEVEL_W(LW), .UNIT_SHIFT(6), .TIME_W(TW), .JAM_STEP(STEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pause_time_cfg(PT), .fill_bytes(fill_bytes), .fdx(fdx), .tx_en(tx_en),
    .frm_start(frm_start), .frm_match(frm_match), .pause_ack(pause_ack),
    .pause_req(pause_req), .pause_time(pause_time), .jam(jam)
  );

  // transmit-side model: accept each visible request once
  always @(negedge clk) begin
    if (pause_req && !pause_ack && !hold_ack) begin
      if (pause_time == '0) n_zero <= n_zero + 1;
      else begin
        n_hi <= n_hi + 1;
        last_hi_time <= pause_time;
      end
      pause_ack <= 1'b1;
    end else begin
      pause_ack <= 1'b0;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  task automatic wr(input logic [7:0] hi, input logic [7:0] lo, input logic [3:0] code, input logic [3:0] mode);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {hi, lo, code, mode};
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic lvl(input int v);
    @(negedge clk);
    fill_bytes = LW'(v);
    repeat (8) @(negedge clk);
  endtask

  task automatic strobe_width(input logic m, output int w);
    @(negedge clk);
    frm_start = 1'b1;
    frm_match = m;
    @(negedge clk);
    frm_start = 1'b0;
    w = 0;
    while (jam && w < 200) begin
      w++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int w, exp_w, h0, z0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(cfg_rdata == 32'h0, "R1 rdata", int'(cfg_rdata), 0);
    chk(!pause_req && !jam, "R1 outputs", int'({pause_req, jam}), 0);

    // R2 layout and upper byte
    wr(8'hFF, 8'hFF, 4'hF, 4'h0);
    chk(cfg_rdata == 32'h00FFFF_F0, "R2 all ones", int'(cfg_rdata), 32'h00FFFFF0);
    wr(8'hA5, 8'h3C, 4'h7, 4'h0);
    chk(cfg_rdata == 32'h00A53C70, "R2 fields", int'(cfg_rdata), 32'h00A53C70);

    // R3/R4 full-duplex sweep over several mark pairs
    fdx = 1'b1;
    for (int hi = 2; hi <= 6; hi++) begin
      int lo;
      lo = hi - 1 - (hi % 2);
      wr(8'(hi), 8'(lo), 4'h3, 4'b0001);
      h0 = n_hi; z0 = n_zero;
      lvl(hi * 64 - 1);
      chk(n_hi == h0, "R3 below high", n_hi - h0, 0);
      lvl(hi * 64);
      chk(n_hi == h0 + 1, "R3 at high", n_hi - h0, 1);
      chk(last_hi_time == PT, "R3 pause time", int'(last_hi_time), int'(PT));
      lvl(hi * 64 + 150);
      chk(n_hi == h0 + 1, "R3 no repeat", n_hi - h0, 1);
      lvl(lo * 64);
      chk(n_zero == z0, "R4 at low", n_zero - z0, 0);
      lvl(lo * 64 - 1);
      chk(n_zero == z0 + 1, "R4 below low", n_zero - z0, 1);
      lvl(0);
      chk(n_zero == z0 + 1 && n_hi == h0 + 1, "R4 single resume", n_zero - z0, 1);
    end

    // R5 no resume without a prior high pause
    wr(8'd5, 8'd3, 4'h0, 4'b0001);
    h0 = n_hi; z0 = n_zero;
    lvl(4 * 64);
    lvl(1);
    chk(n_zero == z0 && n_hi == h0, "R5 no resume", n_zero - z0, 0);

    // R6 request held until acknowledged
    hold_ack = 1'b1;
    lvl(5 * 64);
    repeat (10) @(negedge clk);
    chk(pause_req == 1'b1, "R6 held", int'(pause_req), 1);
    chk(pause_time == PT, "R6 time stable", int'(pause_time), int'(PT));
    hold_ack = 1'b0;
    repeat (4) @(negedge clk);
    chk(pause_req == 1'b0 && n_hi == h0 + 1, "R6 released", n_hi - h0, 1);

    // R13 withdrawing flow control drops the pending resume
    z0 = n_zero;
    wr(8'd5, 8'd3, 4'h0, 4'b0000);
    lvl(0);
    wr(8'd5, 8'd3, 4'h0, 4'b0001);
    repeat (10) @(negedge clk);
    chk(n_zero == z0, "R13 no resume", n_zero - z0, 0);

    // R12 low mark above high mark
    wr(8'd3, 8'd5, 4'h0, 4'b0001);
    h0 = n_hi; z0 = n_zero;
    lvl(4 * 64);
    repeat (20) @(negedge clk);
    chk(n_hi == h0 + 1 && n_zero == z0 + 1, "R12 one pair", (n_hi - h0) * 10 + (n_zero - z0), 11);
    lvl(0);
    lvl(4 * 64);
    chk(n_hi == h0 + 2, "R12 next excursion", n_hi - h0, 2);
    lvl(0);

    // R11 transmitter disabled
    tx_en = 1'b0;
    h0 = n_hi;
    wr(8'd2, 8'd1, 4'h2, 4'b0001);
    lvl(400);
    chk(n_hi == h0 && !pause_req, "R11 no pause", n_hi - h0, 0);
    lvl(0);
    fdx = 1'b0;
    wr(8'd2, 8'd1, 4'h2, 4'b0010);
    lvl(400);
    strobe_width(1'b1, w);
    chk(w == 0, "R11 no jam", w, 0);
    tx_en = 1'b1;

    // R7 jam length for every duration code
    for (int c = 0; c < 16; c++) begin
      wr(8'd2, 8'd1, 4'(c), 4'b0010);
      exp_w = (c + 1) * STEP;
      strobe_width(1'b0, w);
      chk(w == exp_w, "R7 jam width", w, exp_w);
    end
    lvl(127);
    strobe_width(1'b1, w);
    chk(w == 0, "R7 below high", w, 0);
    lvl(128);

    // R8 match qualifier
    wr(8'd2, 8'd1, 4'h4, 4'b0110);
    strobe_width(1'b0, w);
    chk(w == 0, "R8 unmatched", w, 0);
    strobe_width(1'b1, w);
    chk(w == 5 * STEP, "R8 matched", w, 5 * STEP);

    // R9 restart during active jam
    wr(8'd2, 8'd1, 4'h5, 4'b0010);
    @(negedge clk); frm_start = 1'b1; frm_match = 1'b1;
    @(negedge clk); frm_start = 1'b0;
    repeat (3) @(negedge clk);
    chk(jam == 1'b1, "R9 still active", int'(jam), 1);
    strobe_width(1'b1, w);
    chk(w == 6 * STEP, "R9 restarted", w, 6 * STEP);

    // R14 forced jam
    wr(8'd2, 8'd1, 4'h0, 4'b1000);
    repeat (5) @(negedge clk);
    chk(jam == 1'b1, "R14 forced", int'(jam), 1);
    wr(8'd2, 8'd1, 4'h0, 4'b0000);
    chk(jam == 1'b0, "R14 released", int'(jam), 0);

    // R10 full duplex ignores duration and never jams
    fdx = 1'b1;
    wr(8'd2, 8'd1, 4'hF, 4'b1110);
    strobe_width(1'b1, w);
    chk(w == 0 && !jam, "R10 no jam in full duplex", w, 0);

    finish_run();
  end

endmodule